// File: doc/BRIEF.md
# SOA-Gated Charge Pump Driver

This block produces the switching drive for a charge pump that lifts the gate of a high-side power MOSFET above its supply. A free-running oscillator makes an asymmetric square wave with a long high phase and a short low phase. The pump output follows the high phase only when the load current is below the limit for the present load-voltage zone. Because the pump stops as soon as the current passes that limit, it works as a hysteretic inrush limiter and keeps the MOSFET inside its safe operating area while the load capacitance charges.

Two comparator flags on the load voltage select the zone. Below the lower threshold, the tight current limit applies. Between the two thresholds, the looser limit applies. Above the upper threshold, no limit applies. All comparator flags come from asynchronous analog circuits and are synchronized inside the block. A shutdown request stops the pump at once. All pins are plain control levels with no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `soa_pump_drv`

## Requirements
- R1: While `rst_n` is low, `pump_drv` is 0.
- R2: After reset release, with pumping allowed, `pump_drv` is 1 for the `HI_CYC` cycles that follow the first rising edge, then 0 for `LO_CYC` cycles, and this pattern repeats. The defaults are 32 and 8.
- R3: When both load flags are 0 (load in the low zone), the pump runs only while `cur_over_lo` is 0. `cur_over_hi` has no effect in this zone.
- R4: When `ld_above_lo` is 1 and `ld_above_hi` is 0 (middle zone), the pump runs only while `cur_over_hi` is 0. `cur_over_lo` has no effect in this zone.
- R5: When `ld_above_hi` is 1, the pump runs in every high phase, whatever the current flags and `ld_above_lo` are.
- R6: A rising edge that samples `shut_req` at 1 drives `pump_drv` to 0. When `shut_req` returns to 0, the waveform restarts at the beginning of its high phase, with the same timing as after reset.
- R7: A change on a comparator flag reaches `pump_drv` at the third rising edge after the change. Two of those edges are for synchronization and one is for the output register.
- R8: `pump_drv` is never 1 in a cycle that follows an oscillator low-phase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (phase durations are counted in its cycles) |
| rst_n | input | 1 | Asynchronous active-low reset |
| shut_req | input | 1 | Synchronous shutdown request, active high |
| ld_above_lo | input | 1 | Load voltage above the lower zone threshold (asynchronous) |
| ld_above_hi | input | 1 | Load voltage above the upper zone threshold (asynchronous) |
| cur_over_lo | input | 1 | Load current above the tight limit (asynchronous) |
| cur_over_hi | input | 1 | Load current above the loose limit (asynchronous) |
| pump_drv | output | 1 | Registered charge pump drive |

## Verification
Two events can land on the same clock edge: a shutdown request and a current-flag change that would enable pumping again. The bench provokes this by clearing a tripped current flag and raising `shut_req` in the same cycle. It then checks that the output stays low and that the waveform restarts from its high phase after release. A second case lets a current trip arrive during a high phase, and the bench checks the exact edge at which the output drops.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  // Synchronized comparator flags, packed so the synchronizer can treat them as a vector
  typedef struct packed {
    logic ld_hi;   // load above upper zone threshold
    logic ld_lo;   // load above lower zone threshold
    logic i_hi;    // current above loose limit
    logic i_lo;    // current above tight limit
  } cmp_flags_t;

  localparam int unsigned FLAG_W = $bits(cmp_flags_t);

  typedef enum logic [1:0] {
    ZONE_LOW  = 2'd0,
    ZONE_MID  = 2'd1,
    ZONE_FREE = 2'd2
  } load_zone_e;
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cpd_osc.sv
module cpd_osc #(
  parameter int unsigned HI_CYC = 32,
  parameter int unsigned LO_CYC = 8,
  localparam int unsigned PERIOD = HI_CYC + LO_CYC,
  localparam int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] phase,
  output logic          osc_hi
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HI_END = CW'(HI_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= '0;
    else if (restart)      phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign osc_hi = (phase < HI_END);
endmodule

// File: rtl/cpd_gate.sv
module cpd_gate
  import cpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shut,
  input  logic       osc_hi,
  input  cmp_flags_t flags,
  output load_zone_e zone,
  output logic       pump
);
  logic allow;

  always_comb begin
    if (flags.ld_hi)      zone = ZONE_FREE;
    else if (flags.ld_lo) zone = ZONE_MID;
    else                  zone = ZONE_LOW;
    unique case (zone)
      ZONE_LOW:  allow = !flags.i_lo;
      ZONE_MID:  allow = !flags.i_hi;
      ZONE_FREE: allow = 1'b1;
      default:   allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pump <= 1'b0;
    else if (shut) pump <= 1'b0;
    else           pump <= osc_hi & allow;
  end
endmodule

// File: rtl/soa_pump_drv.sv
module soa_pump_drv
  import cpd_pkg::*;
#(
  parameter int unsigned HI_CYC      = 32,
  parameter int unsigned LO_CYC      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_req,
  input  logic ld_above_lo,
  input  logic ld_above_hi,
  input  logic cur_over_lo,
  input  logic cur_over_hi,
  output logic pump_drv
);
  localparam int unsigned CW = $clog2(HI_CYC + LO_CYC);

  cmp_flags_t    raw_flags;
  logic [FLAG_W-1:0] sync_vec;
  cmp_flags_t    flg_s;
  logic [CW-1:0] ph_q;
  logic          osc_hi;
  load_zone_e    zone;

  assign raw_flags = '{ld_hi: ld_above_hi, ld_lo: ld_above_lo,
                       i_hi: cur_over_hi, i_lo: cur_over_lo};

  cpd_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_flags),
    .q_sync  (sync_vec)
  );
  assign flg_s = cmp_flags_t'(sync_vec);

  cpd_osc #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (shut_req),
    .phase   (ph_q),
    .osc_hi  (osc_hi)
  );

  cpd_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .shut   (shut_req),
    .osc_hi (osc_hi),
    .flags  (flg_s),
    .zone   (zone),
    .pump   (pump_drv)
  );
endmodule

// File: rtl/soa_pump_drv_chk.sv
module soa_pump_drv_chk #(
  parameter int unsigned HI_CYC = 32,
  parameter int unsigned LO_CYC = 8,
  localparam int unsigned PERIOD = HI_CYC + LO_CYC,
  localparam int unsigned CW     = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shut_req,
  input logic          pump_drv,
  input logic [CW-1:0] ph,
  input logic          s_ld_hi,
  input logic          s_ld_lo,
  input logic          s_i_hi,
  input logic          s_i_lo
);
  localparam logic [CW-1:0] HI_END = CW'(HI_CYC);
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);

  a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !pump_drv);

  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= LAST);

  a_r8_quiet_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (ph >= HI_END) |=> !pump_drv);

  a_r3_low_zone_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ld_hi && !s_ld_lo && s_i_lo) |=> !pump_drv);

  a_r4_mid_zone_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ld_hi && s_ld_lo && s_i_hi) |=> !pump_drv);

  a_r5_free_zone_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ld_hi && (ph < HI_END) && !shut_req) |=> pump_drv);

  a_r6_shut_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> (!pump_drv && ph == '0));
endmodule

bind soa_pump_drv soa_pump_drv_chk #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shut_req (shut_req),
  .pump_drv (pump_drv),
  .ph       (ph_q),
  .s_ld_hi  (flg_s.ld_hi),
  .s_ld_lo  (flg_s.ld_lo),
  .s_i_hi   (flg_s.i_hi),
  .s_i_lo   (flg_s.i_lo)
);

// File: tb/sim_soa_pump_drv.sv
`timescale 1ns/1ps
module sim_soa_pump_drv;
  localparam int HI = 32;
  localparam int LO = 8;
  localparam int P  = HI + LO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shut_req = 1'b0;
  logic vlo = 1'b0, vhi = 1'b0, ilo = 1'b0, ihi = 1'b0;
  logic pump_drv;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  soa_pump_drv #(.HI_CYC(HI), .LO_CYC(LO)) u0 (
    .clk(clk), .rst_n(rst_n), .shut_req(shut_req),
    .ld_above_lo(vlo), .ld_above_hi(vhi),
    .cur_over_lo(ilo), .cur_over_hi(ihi),
    .pump_drv(pump_drv)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_flags(input logic a_lo, input logic a_hi, input logic c_lo, input logic c_hi);
    vlo = a_lo; vhi = a_hi; ilo = c_lo; ihi = c_hi;
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (pump_drv) n++;
    end
  endtask

  // R1: output low throughout reset
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 reset low", pump_drv, 0);
    end
  endtask

  // R2 / R8: exact waveform over two periods after reset release
  task automatic t_pattern();
    set_flags(0, 0, 0, 0);
    t_reset();
    rst_n = 1'b1;
    for (int n = 1; n <= 2 * P; n++) begin
      @(negedge clk);
      check("R2 waveform", pump_drv, (((n - 1) % P) < HI) ? 1 : 0);
    end
  endtask

  task automatic gate_case(input string req, input logic a_lo, input logic a_hi,
                           input logic c_lo, input logic c_hi, input int exp);
    int n;
    @(negedge clk);
    set_flags(a_lo, a_hi, c_lo, c_hi);
    repeat (4) @(negedge clk);
    count_high(n);
    check(req, n, exp);
  endtask

  // R3: low zone uses the tight limit only
  task automatic t_low_zone();
    gate_case("R3 low zone under", 0, 0, 0, 0, HI);
    gate_case("R3 low zone over tight", 0, 0, 1, 0, 0);
    gate_case("R3 low zone loose ignored", 0, 0, 0, 1, HI);
  endtask

  // R4: middle zone uses the loose limit only
  task automatic t_mid_zone();
    gate_case("R4 mid zone tight ignored", 1, 0, 1, 0, HI);
    gate_case("R4 mid zone over loose", 1, 0, 1, 1, 0);
    gate_case("R4 mid zone under", 1, 0, 0, 0, HI);
  endtask

  // R5: above upper threshold no limit
  task automatic t_free_zone();
    gate_case("R5 free zone both over", 1, 1, 1, 1, HI);
    gate_case("R5 free zone lo flag clear", 0, 1, 1, 1, HI);
  endtask

  // R6: shutdown holds low, restart from high phase; collides with a re-enable
  task automatic t_shutdown();
    gate_case("R6 pre tripped", 0, 0, 1, 0, 0);
    @(negedge clk);
    shut_req = 1'b1;
    ilo = 1'b0;          // re-enable and shutdown on the same edge
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R6 shut holds low", pump_drv, 0);
    end
    shut_req = 1'b0;
    for (int n = 1; n <= P + 2; n++) begin
      @(negedge clk);
      check("R6 restart waveform", pump_drv, (((n - 1) % P) < HI) ? 1 : 0);
    end
  endtask

  // R7: flag change reaches the output on the third edge
  task automatic t_latency();
    set_flags(0, 0, 0, 0);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 running before trip", pump_drv, 1);
    ilo = 1'b1;
    @(negedge clk);
    check("R7 edge one still high", pump_drv, 1);
    @(negedge clk);
    check("R7 edge two still high", pump_drv, 1);
    @(negedge clk);
    check("R7 edge three low", pump_drv, 0);
    ilo = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 release edge two still low", pump_drv, 0);
    @(negedge clk);
    check("R7 release edge three high", pump_drv, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_pattern();
    t_low_zone();
    t_mid_zone();
    t_free_zone();
    t_shutdown();
    t_latency();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule